// File: doc/BRIEF.md
# Processor Cycle Counter Register

This block holds a 64-bit time-stamp word that a processor reads to measure elapsed clock cycles. The low half is a 32-bit counter that advances once per clock while its enable flag is set. The high half is a 32-bit storage field where software keeps an offset. The counter never carries into this field.

Each half has its own write path. A register-write strobe loads only the offset half and leaves the counter running. A separate write-only control strobe loads the counter and sets or clears its enable. The control word carries the enable at bit 32 and counter bits [31:4] at the same positions. A read strobe returns the whole 64-bit word one cycle later.

Top module: `cyc_counter_reg`

## Requirements
- R1: After reset the offset half and the counter are zero and the enable is clear, so the count stays zero until a control write enables it.
- R2: While the enable is set and no control write occurs, the counter (bits [31:0]) increases by exactly one on every clock.
- R3: While the enable is clear and no control write occurs, the counter keeps its value.
- R4: A register write loads word bits [63:32] into the offset half only. Bits [31:0] of that write are ignored, and the counter keeps counting or holding as it would without the write.
- R5: A read strobe sampled at a clock edge raises `rd_valid` for exactly the next cycle. `rd_data` then holds {offset, counter} as they stood just before that edge, so writes in the same cycle are not yet visible.
- R6: A control write sets the enable from word bit 32 (1 = count, 0 = stop). It loads counter bits [31:4] from word bits [31:4] and forces counter bits [3:0] to zero. Word bits [63:33] and [3:0] have no effect.
- R7: The counter wraps from 0xFFFFFFFF to 0x00000000, and the offset half does not change when it wraps.
- R8: When a control write meets a pending increment, the written value is taken unchanged. The first increment follows on the next clock if the new enable is set.
- R9: A register write and a control write in the same cycle both take full effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register-write strobe (loads offset half) |
| reg_wdata | input | 64 | Register-write data; bits [63:32] used |
| ctl_wr | input | 1 | Control-write strobe |
| ctl_wdata | input | 64 | Control word: bit 32 enable, bits [31:4] counter load |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read result valid, one cycle after `rd_en` |
| rd_data | output | 64 | Read result {offset, counter} |

## Verification
The counter is read after idle stretches with the enable both set and clear. These reads separate counting from holding, and they show the per-cycle step size. Control words carry junk in bits [63:33] and [3:0], which exposes any leak into the enable or the low nibble. A read issued on the same cycle as a control write, followed by one on the next cycle, pins down both the old-value read and the rule that a write beats an increment. A load just below 0xFFFFFFFF under a known offset checks the wrap and shows that no carry reaches the upper half. Simultaneous register and control writes, and a register write carrying low-half junk, show that the two write paths stay apart.

// File: rtl/cyc_counter_pkg.sv
package cyc_counter_pkg;
    // default half-word width; the full word is twice this
    localparam int unsigned HALF_W_DEF    = 32;
    // counter bits below this index are cleared by a control load
    localparam int unsigned FIXED_LSB_DEF = 4;
endpackage

// File: rtl/cyc_ctl_decode.sv
module cyc_ctl_decode #(
    parameter int unsigned HALF_W    = cyc_counter_pkg::HALF_W_DEF,
    parameter int unsigned FIXED_LSB = cyc_counter_pkg::FIXED_LSB_DEF
) (
    input  logic [HALF_W:FIXED_LSB]  ctl_field,
    output logic [HALF_W-1:0]        load_val,
    output logic                     load_ena
);
    localparam int unsigned LOAD_W = HALF_W - FIXED_LSB;

    logic [LOAD_W-1:0] load_bits;

    always_comb begin
        load_bits = ctl_field[HALF_W-1:FIXED_LSB];
        load_ena  = ctl_field[HALF_W];
        load_val  = {load_bits, {FIXED_LSB{1'b0}}};
    end
endmodule

// File: rtl/cyc_lo_counter.sv
module cyc_lo_counter #(
    parameter int unsigned HALF_W = cyc_counter_pkg::HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [HALF_W-1:0] load_val,
    input  logic              load_ena,
    output logic [HALF_W-1:0] cnt,
    output logic              ena
);
    typedef struct packed {
        logic              ena;
        logic [HALF_W-1:0] cnt;
    } lo_state_t;

    lo_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.ena = load_ena;
            st_d.cnt = load_val;
        end else if (st_q.ena) begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ena = st_q.ena;
endmodule

// File: rtl/cyc_hi_store.sv
module cyc_hi_store #(
    parameter int unsigned HALF_W = cyc_counter_pkg::HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [HALF_W-1:0] wr_val,
    output logic [HALF_W-1:0] val
);
    typedef struct packed {
        logic [HALF_W-1:0] offs;
    } hi_state_t;

    hi_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.offs = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.offs;
endmodule

// File: rtl/cyc_rd_port.sv
module cyc_rd_port #(
    parameter int unsigned WORD_W = 2 * cyc_counter_pkg::HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] word,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_en;
        if (rd_en) st_d.data = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.vld;
    assign rd_data  = st_q.data;
endmodule

// File: rtl/cyc_counter_reg.sv
module cyc_counter_reg #(
    parameter int unsigned HALF_W    = cyc_counter_pkg::HALF_W_DEF,
    parameter int unsigned FIXED_LSB = cyc_counter_pkg::FIXED_LSB_DEF,
    parameter int unsigned WORD_W    = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              ctl_wr,
    input  logic [WORD_W-1:0] ctl_wdata,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data
);
    localparam int unsigned ENA_BIT = HALF_W;

    logic [HALF_W-1:0] lo_val;
    logic [HALF_W-1:0] hi_val;
    logic              count_ena;
    logic [HALF_W-1:0] ctl_load_val;
    logic              ctl_load_ena;
    logic              unused_bits;

    // bits outside both write layouts carry no meaning
    assign unused_bits = ^{ctl_wdata[WORD_W-1:ENA_BIT+1],
                           ctl_wdata[FIXED_LSB-1:0],
                           reg_wdata[HALF_W-1:0]};

    cyc_ctl_decode #(
        .HALF_W    (HALF_W),
        .FIXED_LSB (FIXED_LSB)
    ) ctl_dec_i (
        .ctl_field (ctl_wdata[ENA_BIT:FIXED_LSB]),
        .load_val  (ctl_load_val),
        .load_ena  (ctl_load_ena)
    );

    cyc_lo_counter #(
        .HALF_W (HALF_W)
    ) lo_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (ctl_wr),
        .load_val (ctl_load_val),
        .load_ena (ctl_load_ena),
        .cnt      (lo_val),
        .ena      (count_ena)
    );

    cyc_hi_store #(
        .HALF_W (HALF_W)
    ) hi_st_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_val (reg_wdata[WORD_W-1:HALF_W]),
        .val    (hi_val)
    );

    cyc_rd_port #(
        .WORD_W (WORD_W)
    ) rd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .word     ({hi_val, lo_val}),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/cyc_counter_reg_chk.sv
module cyc_counter_reg_chk #(
    parameter int unsigned HALF_W    = cyc_counter_pkg::HALF_W_DEF,
    parameter int unsigned FIXED_LSB = cyc_counter_pkg::FIXED_LSB_DEF,
    parameter int unsigned WORD_W    = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              ctl_wr,
    input logic [WORD_W-1:0] ctl_wdata,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [HALF_W-1:0] lo_val,
    input logic [HALF_W-1:0] hi_val,
    input logic              count_ena
);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_ena && !ctl_wr) |=> (lo_val == $past(lo_val) + HALF_W'(1)));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_ena && !ctl_wr) |=> $stable(lo_val));

    // R4
    offs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (hi_val == $past(reg_wdata[WORD_W-1:HALF_W])));

    // R4
    offs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(hi_val));

    // R5
    rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R5
    rd_valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R6
    low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (lo_val[FIXED_LSB-1:0] == '0));

    // R6
    ena_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (count_ena == $past(ctl_wdata[HALF_W])));

    // R8
    ctl_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (lo_val[HALF_W-1:FIXED_LSB] == $past(ctl_wdata[HALF_W-1:FIXED_LSB])));
endmodule

bind cyc_counter_reg cyc_counter_reg_chk #(
    .HALF_W    (HALF_W),
    .FIXED_LSB (FIXED_LSB),
    .WORD_W    (WORD_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .lo_val    (lo_val),
    .hi_val    (hi_val),
    .count_ena (count_ena)
);

// File: tb/cyc_counter_reg_tb_top.sv
module cyc_counter_reg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic        ctl_wr = 1'b0;
    logic [63:0] ctl_wdata = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [63:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // reference state, advanced alongside each driven cycle
    logic [31:0] lo_m = '0;
    logic [31:0] hi_m = '0;
    logic        ena_m = 1'b0;

    logic [63:0] exp_val_q[$];
    string       exp_req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_counter_reg dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .rd_en     (rd_en),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // driver: applies one cycle of stimulus and queues any expected read
    task automatic step(input logic rw, input logic [63:0] rwd,
                        input logic cw, input logic [63:0] cwd,
                        input logic rd, input string req);
        logic [31:0] lo_n;
        @(negedge clk);
        reg_wr = rw; reg_wdata = rwd;
        ctl_wr = cw; ctl_wdata = cwd;
        rd_en  = rd;
        if (rd) begin
            exp_val_q.push_back({hi_m, lo_m});
            exp_req_q.push_back(req);
        end
        lo_n = cw ? {cwd[31:4], 4'h0} : (ena_m ? lo_m + 32'd1 : lo_m);
        if (cw) ena_m = cwd[32];
        if (rw) hi_m = rwd[63:32];
        lo_m = lo_n;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, 1'b0, "");
    endtask

    task automatic rd(input string req);
        step(1'b0, '0, 1'b0, '0, 1'b1, req);
    endtask

    // monitor: pops expected reads as results appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_val_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL R5: actual unexpected rd_valid expected none pending");
            end else begin
                check(exp_req_q.pop_front(), rd_data, exp_val_q.pop_front());
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet and zero under reset
        check("R1", {63'd0, rd_valid}, 64'd0);
        check("R1", rd_data, 64'd0);
        rst_n = 1'b1;
        rd("R1");
        idle(6);
        rd("R1");   // enable clear after reset: still zero

        // R6/R8: enable with junk in upper and low bits
        step(1'b0, '0, 1'b1, 64'hFFFF_FFFF_0000_010F | (64'd1 << 32), 1'b1, "R5");
        rd("R8");   // written value, not yet incremented
        rd("R2");
        idle(4);
        rd("R2");

        // R4: offset write with junk low half; counter keeps running
        step(1'b1, 64'hDEAD_BEEF_1234_5678, 1'b0, '0, 1'b1, "R5");
        rd("R4");
        idle(2);
        rd("R4");

        // R3/R6: stop with a load; low nibble forced to zero
        step(1'b0, '0, 1'b1, 64'hAAAA_AAAA_5555_555F & ~(64'd1 << 32), 1'b0, "");
        rd("R6");
        idle(7);
        rd("R3");

        // R7: wrap without carry into the offset
        step(1'b0, '0, 1'b1, 64'h0000_0001_FFFF_FFF7, 1'b0, "");
        rd("R7");
        idle(14);
        rd("R7");
        idle(3);
        rd("R7");

        // R9: both write paths in one cycle
        step(1'b1, 64'h0123_4567_89AB_CDEF, 1'b1, 64'h0000_0001_0000_1230, 1'b1, "R5");
        rd("R9");
        rd("R9");

        // R8: reload while counting; R6 disable through bit 32 only
        idle(3);
        step(1'b0, '0, 1'b1, 64'hFFFF_FFFE_0000_0040, 1'b0, "");
        rd("R8");
        idle(2);
        rd("R6");

        idle(3);
        if (exp_val_q.size() != 0)
            check("R5", 64'(exp_val_q.size()), 64'd0);
        done = 1'b1;
        report();
    end
endmodule